// File: doc/BRIEF.md
# Transition-Kicked Watchdog Timer

This block watches a processor "alive" signal. Software toggles a kick line; every change of level, rising or falling, restarts an internal cycle counter. If the line holds one level for a full timeout interval, the block drives its active-low timeout flag low. The flag stays low until a clearing condition arrives. A clearing condition is a kick transition, an asserted processor reset, or a kick line reported as undriven.

An undriven kick line disables the watchdog by holding the timer cleared. The decision that the line is undriven is made outside the block and arrives here as a flag. The flag output is also forced low whenever the supply-good input is deasserted. When the supply recovers, the flag rises in the same cycle, with no minimum low time. Feeding the flag back into a reset source is left to the surrounding logic. The interval is the parameter `WDT_CYCLES`, counted in clock cycles.

Top module: `edge_wdt`

## Requirements
- R1: With no clearing condition, the flag `wdt_n` stays high for the first `WDT_CYCLES`-1 clock edges after the last clear. It reads low after the `WDT_CYCLES`-th such edge, whether the kick line is held high or held low.
- R2: A rising transition of `kick` (level 1 now, level 0 in the previous cycle) is a clearing condition.
- R3: A falling transition of `kick` (level 0 now, level 1 in the previous cycle) is a clearing condition.
- R4: While `cpu_rst` is 1, the timer is held cleared and `wdt_n` follows `supply_ok`.
- R5: While `kick_hiz` is 1, the watchdog is disabled: the timer is held cleared and `wdt_n` follows `supply_ok`.
- R6: Once timed out, `wdt_n` stays low until a clearing condition is present.
- R7: Whenever `supply_ok` is 0, `wdt_n` is 0, in the same cycle.
- R8: When `supply_ok` returns to 1 and the timer has not expired, `wdt_n` is 1 in that same cycle, with no stretch.
- R9: In a cycle where a clearing condition is present, `wdt_n` equals `supply_ok`, even after a timeout. The count restarts from zero at the next edge, so a full `WDT_CYCLES` interval is needed again before the next timeout.
- R10: During and right after `rst_n` low, the timer is clear and the stored previous kick level is 0. A kick level of 1 in the first cycle therefore counts as a rising transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick | input | 1 | Synchronised kick level |
| kick_hiz | input | 1 | 1 when the kick line is undriven |
| supply_ok | input | 1 | 1 when the supply is above threshold |
| cpu_rst | input | 1 | 1 while the processor reset is asserted |
| wdt_n | output | 1 | Active-low watchdog timeout flag |

## Verification
Every cycle, the assertions check four things:
- `wdt_n` is low whenever the supply is low.
- A clearing condition, an undriven kick line or a held processor reset keeps the flag at the supply level.
- A low flag with the supply good stays low until something clears it.
- An expiry event pulls the flag low at the next edge.

Only the bench scenarios can show the exact interval length. They also show that a clear truly restarts the count from zero, that the first cycle after reset treats a high kick as a transition, and that the flag rises in the same cycle the supply returns.

// File: rtl/edge_wdt_pkg.sv
package edge_wdt_pkg;

  // Next counter value: zero on clear, hold at the top, otherwise advance.
  function automatic int unsigned wdt_count_next(input int unsigned cnt,
                                                 input logic        clr,
                                                 input int unsigned top);
    if (clr)            return 0;
    else if (cnt >= top) return top;
    else                return cnt + 1;
  endfunction

  // True on the edge where the count sits on its last value and is not cleared.
  function automatic logic wdt_expiry(input int unsigned cnt,
                                      input logic        clr,
                                      input int unsigned top);
    return (!clr) && (cnt == top);
  endfunction

endpackage

// File: rtl/kick_edge_det.sv
module kick_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic edge_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= kick_i;
  end

  assign edge_o = kick_i ^ prev_q;
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import edge_wdt_pkg::*;
#(
  parameter int unsigned WDT_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic expire_o,
  output logic expired_o
);
  localparam int unsigned TOP = (WDT_CYCLES > 1) ? WDT_CYCLES - 1 : 0;
  localparam int unsigned CW  = (TOP > 0) ? $clog2(TOP + 1) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          expired_q;

  always_comb begin
    cnt_d    = CW'(wdt_count_next(int'(cnt_q), clear_i, TOP));
    expire_o = wdt_expiry(int'(cnt_q), clear_i, TOP) && !expired_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      expired_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (clear_i)       expired_q <= 1'b0;
      else if (expire_o) expired_q <= 1'b1;
    end
  end

  assign expired_o = expired_q;
endmodule

// File: rtl/edge_wdt.sv
module edge_wdt #(
  parameter int unsigned WDT_CYCLES = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  logic kick_hiz,
  input  logic supply_ok,
  input  logic cpu_rst,
  output logic wdt_n
);
  logic edge_evt;
  logic clear_evt;
  logic expire_evt;
  logic expired;

  kick_edge_det u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .kick_i (kick),
    .edge_o (edge_evt)
  );

  assign clear_evt = edge_evt | kick_hiz | cpu_rst;

  wdt_timer #(.WDT_CYCLES(WDT_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear_evt),
    .expire_o  (expire_evt),
    .expired_o (expired)
  );

  assign wdt_n = supply_ok & ~(expired & ~clear_evt);
endmodule

// File: rtl/edge_wdt_checker.sv
module edge_wdt_checker (
  input logic clk,
  input logic rst_n,
  input logic kick_hiz,
  input logic supply_ok,
  input logic cpu_rst,
  input logic wdt_n,
  input logic clear_evt,
  input logic expire_evt
);
  p_supply_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !wdt_n);

  p_clear_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_evt |-> (wdt_n == supply_ok));

  p_hiz_disable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_hiz |-> (wdt_n == supply_ok));

  p_cpu_rst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst |-> (wdt_n == supply_ok));

  p_latched_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wdt_n && supply_ok) |=> (!supply_ok || clear_evt || !wdt_n));

  p_expiry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (!wdt_n || clear_evt || !supply_ok));
endmodule

bind edge_wdt edge_wdt_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .kick_hiz   (kick_hiz),
  .supply_ok  (supply_ok),
  .cpu_rst    (cpu_rst),
  .wdt_n      (wdt_n),
  .clear_evt  (clear_evt),
  .expire_evt (expire_evt)
);

// File: tb/edge_wdt_bench.sv
module edge_wdt_bench;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick = 1'b0, kick_hiz = 1'b0, supply_ok = 1'b1, cpu_rst = 1'b0;
  logic wdt_n;

  int n_chk = 0, n_bad = 0;
  int quiet = 0;       // model: edges since last clear, saturating at W
  logic m_prev = 1'b0; // model: kick level of the previous cycle

  always #2 clk = ~clk; // 250 MHz

  edge_wdt #(.WDT_CYCLES(W)) u_edge_wdt (
    .clk(clk), .rst_n(rst_n), .kick(kick), .kick_hiz(kick_hiz),
    .supply_ok(supply_ok), .cpu_rst(cpu_rst), .wdt_n(wdt_n)
  );

  function automatic logic model_clear(input logic k, input logic p,
                                       input logic hz, input logic cr);
    return (k != p) || hz || cr;
  endfunction

  function automatic logic model_out(input int q, input logic clr, input logic sup);
    if (!sup) return 1'b0;
    if (clr)  return 1'b1;
    return (q >= W) ? 1'b0 : 1'b1;
  endfunction

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (wdt_n !== exp) begin
      n_bad++;
      $display("FAIL %s: wdt_n=%b expected %b (t=%0t)", tag, wdt_n, exp, $time);
    end
  endtask

  // Drive one cycle, check mid-cycle, then advance the model across the edge.
  task automatic step(input logic k, input logic hz, input logic sup,
                      input logic cr, input string tag);
    logic clr;
    @(posedge clk);
    #1;
    kick = k; kick_hiz = hz; supply_ok = sup; cpu_rst = cr;
    #1;
    clr = model_clear(k, m_prev, hz, cr);
    check(model_out(quiet, clr, sup), tag);
    quiet  = clr ? 0 : ((quiet < W) ? quiet + 1 : quiet);
    m_prev = k;
  endtask

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    #3;
    check(1'b1, "R10 reset state");
    @(posedge clk); #1; rst_n = 1'b1;
    // R10: first cycle with kick=1 counts as a rising transition
    step(1'b1, 1'b0, 1'b1, 1'b0, "R10");
    // R1: held high, boundary of the interval
    for (int i = 0; i < W; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R1 held high");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R6 latched low");
    // R3: falling transition releases
    step(1'b0, 1'b0, 1'b1, 1'b0, "R3 falling edge");
    // R1 held low then R2 rising
    for (int i = 0; i < W + 2; i++) step(1'b0, 1'b0, 1'b1, 1'b0, "R1 held low");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R2 rising edge");
    // R9: full interval needed again
    for (int i = 0; i < W; i++) step(1'b1, 1'b0, 1'b1, 1'b0, "R9 restart");
    // R5: undriven line disables
    for (int i = 0; i < 3 * W; i++) step(1'b1, 1'b1, 1'b1, 1'b0, "R5 hiz");
    // R4: processor reset holds clear
    for (int i = 0; i < 3 * W; i++) step(1'b1, 1'b0, 1'b1, 1'b1, "R4 cpu reset");
    // R7 / R8: supply dip while counting, then immediate return
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b0, "R7 supply low");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R8 supply return");
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic k, hz, sup, cr, clr;
      string tag;
      k   = ($urandom % 16 == 0) ? ~m_prev : m_prev;
      hz  = ($urandom % 40 == 0);
      cr  = ($urandom % 40 == 0);
      sup = ($urandom % 25 != 0);
      clr = model_clear(k, m_prev, hz, cr);
      if (!sup)          tag = "R7";
      else if (clr)      tag = "R9";
      else if (quiet >= W) tag = "R6";
      else               tag = "R1";
      step(k, hz, sup, cr, tag);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule